// File: doc/BRIEF.md
# Debug Link Fault Guard

This block watches a half-duplex, single-wire, open-drain serial link that joins a host to an on-chip debugger. It looks for three faults. The first is a host break, where the line stays low for a run of whole bit periods. The second is a framing fault, where a received stop bit is sampled low. The third is a transmit collision, where the debugger releases the line to send a one but senses it low at the bit's sample point.

When it sees any of these faults, the block does three things. It pulses an abort to the command logic. It pulses a recalibration request to the baud-rate detector. It then pulls the shared line low for a fixed number of system clock cycles. Because the wire is open-drain, this returned break can only lengthen a host break that ended early; it never fights the host.

After the break, the block releases the line and waits until the line reads high. It then signals ready again. While it is in break or waiting, further faults are ignored. During normal operation the block also acts as the line's pull-down driver for the debugger's transmit bits.

Top module: `dbg_link_guard`

## Requirements
- R1: After reset, `ready_o` is 1, `abort_o` and `baud_rst_o` are 0, and `pull_low_o` is 0 while `tx_en` is 0.
- R2: While ready, the line is sampled on each `bit_tick` and the low bit periods are counted; the count clears on any cycle in which the line reads high. A fault is raised on the `bit_tick` that makes BRK_BITS (default 9) consecutive low bit periods. Eight low periods followed by a high line raise nothing.
- R3: While ready, a `stop_vld` strobe with `stop_bit` = 0 (line low) raises a fault. A `stop_vld` strobe with `stop_bit` = 1 raises none.
- R4: While ready, a cycle with `samp_tick`, `tx_en` and `tx_bit` all 1 and `line_in` = 0 raises a fault. A low line without `samp_tick`, or with `tx_bit` = 0, raises none.
- R5: A fault raised on a clock edge makes `abort_o` and `baud_rst_o` both 1 for exactly the one cycle that follows that edge.
- R6: From that same cycle, `pull_low_o` is 1 for exactly BREAK_CLKS (default 4096) consecutive cycles.
- R7: During the break and the wait that follows it, faults of every kind are ignored: no further pulses occur and the break is not lengthened.
- R8: After the break, `ready_o` stays 0 until a clock edge that samples `line_in` = 1; it is 1 from the cycle after that edge.
- R9: While ready, `pull_low_o` equals `tx_en` AND NOT `tx_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe at each bit-period boundary from the baud block |
| samp_tick | input | 1 | One-cycle strobe at the settled sample point of a transmitted bit |
| stop_vld | input | 1 | Strobe: the stop bit of a received frame is being presented |
| stop_bit | input | 1 | Sampled stop-bit value (1 = high, correct) |
| tx_en | input | 1 | Debugger is transmitting |
| tx_bit | input | 1 | Bit being transmitted (0 = pull low) |
| line_in | input | 1 | Sensed level of the shared wire |
| abort_o | output | 1 | One-cycle pulse: abandon the active command |
| baud_rst_o | output | 1 | One-cycle pulse: restart baud-rate detection |
| pull_low_o | output | 1 | Open-drain pull-down enable for the wire |
| ready_o | output | 1 | Guard is idle and fault detection is armed |

## Verification
The assertions check the following on every cycle. An abort is always a single cycle, it comes together with the baud reset and with the start of the pull-down, and it only comes out of the ready state. Every break run lasts exactly BREAK_CLKS cycles, and ready returns only after a high line. Only the bench's scenarios can show the rest: that eight low bits are tolerated and nine are not, that the stop-bit and collision checks separate good inputs from bad ones, that faults injected during a break leave no trace, and that a host holding the line beyond the returned break keeps the guard waiting.

// File: rtl/dbg_guard_pkg.sv
package dbg_guard_pkg;

  typedef enum logic [1:0] {
    LG_RUN    = 2'd0,
    LG_BREAK  = 2'd1,
    LG_SETTLE = 2'd2
  } lg_state_e;

  // True when the count about to be incremented reaches the limit
  function automatic logic hits_limit(int unsigned cnt, int unsigned limit);
    return (cnt + 1) == limit;
  endfunction

  // Collision: released line (sending one) read back low at the sample point
  function automatic logic collided(logic samp, logic txe, logic txb, logic line);
    return samp & txe & txb & ~line;
  endfunction

endpackage

// File: rtl/dbg_low_run.sv
module dbg_low_run #(
  parameter int unsigned BRK_BITS = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic bit_tick,
  input  logic line_in,
  output logic brk_evt
);
  import dbg_guard_pkg::*;

  localparam int unsigned RW = $clog2(BRK_BITS + 1);

  logic [RW-1:0] low_bits;

  always_ff @(posedge clk) begin
    if (!rst_n || !armed || line_in) begin
      low_bits <= '0;
    end else if (bit_tick && (low_bits != RW'(BRK_BITS))) begin
      low_bits <= low_bits + 1'b1;
    end
  end

  assign brk_evt = armed & bit_tick & ~line_in & hits_limit(int'(low_bits), BRK_BITS);

  // R2: a break event only follows a line that was already low on the previous cycle
  assert_brk_needs_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_evt && BRK_BITS > 1) |-> (low_bits != '0));

endmodule

// File: rtl/dbg_fault_detect.sv
module dbg_fault_detect (
  input  logic armed,
  input  logic brk_evt,
  input  logic stop_vld,
  input  logic stop_bit,
  input  logic samp_tick,
  input  logic tx_en,
  input  logic tx_bit,
  input  logic line_in,
  output logic frame_evt,
  output logic coll_evt,
  output logic fault
);
  import dbg_guard_pkg::*;

  assign frame_evt = armed & stop_vld & ~stop_bit;
  assign coll_evt  = armed & collided(samp_tick, tx_en, tx_bit, line_in);
  assign fault     = brk_evt | frame_evt | coll_evt;

endmodule

// File: rtl/dbg_break_gen.sv
module dbg_break_gen #(
  parameter int unsigned BREAK_CLKS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  input  logic line_in,
  output logic brk_active,
  output logic ready,
  output logic abort_p,
  output logic brst_p
);
  import dbg_guard_pkg::*;

  localparam int unsigned CW = (BREAK_CLKS > 1) ? $clog2(BREAK_CLKS) : 1;
  localparam int unsigned LW = $clog2(BREAK_CLKS + 1);

  lg_state_e       state;
  logic [CW-1:0]   hold_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= LG_RUN;
      hold_cnt <= '0;
      abort_p  <= 1'b0;
      brst_p   <= 1'b0;
    end else begin
      abort_p <= 1'b0;
      brst_p  <= 1'b0;
      unique case (state)
        LG_RUN: if (fault) begin
          state    <= LG_BREAK;
          hold_cnt <= '0;
          abort_p  <= 1'b1;
          brst_p   <= 1'b1;
        end
        LG_BREAK: begin
          hold_cnt <= hold_cnt + 1'b1;
          if (hits_limit(int'(hold_cnt), BREAK_CLKS)) state <= LG_SETTLE;
        end
        LG_SETTLE: if (line_in) state <= LG_RUN;
        default: state <= LG_RUN;
      endcase
    end
  end

  assign brk_active = (state == LG_BREAK);
  assign ready      = (state == LG_RUN);

  // Independent run-length counter for the break-length check
  logic [LW-1:0] run_len;
  always_ff @(posedge clk) begin
    if (!rst_n || !brk_active) run_len <= '0;
    else                       run_len <= run_len + 1'b1;
  end

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_p |=> !abort_p);
  assert_pulse_paired_R5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_p |-> (brst_p && brk_active && run_len == '0));
  assert_break_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_active) |-> (run_len == LW'(BREAK_CLKS)));
  assert_break_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_active |-> (run_len < LW'(BREAK_CLKS)));
  assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_p |-> $past(ready));
  assert_ready_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(line_in));

endmodule

// File: rtl/dbg_link_guard.sv
module dbg_link_guard #(
  parameter int unsigned BRK_BITS   = 9,
  parameter int unsigned BREAK_CLKS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic samp_tick,
  input  logic stop_vld,
  input  logic stop_bit,
  input  logic tx_en,
  input  logic tx_bit,
  input  logic line_in,
  output logic abort_o,
  output logic baud_rst_o,
  output logic pull_low_o,
  output logic ready_o
);

  logic brk_evt, frame_evt, coll_evt, fault;
  logic brk_active, ready;

  dbg_low_run #(.BRK_BITS(BRK_BITS)) u_low_run (
    .clk(clk), .rst_n(rst_n), .armed(ready), .bit_tick(bit_tick),
    .line_in(line_in), .brk_evt(brk_evt)
  );

  dbg_fault_detect u_fault (
    .armed(ready), .brk_evt(brk_evt), .stop_vld(stop_vld), .stop_bit(stop_bit),
    .samp_tick(samp_tick), .tx_en(tx_en), .tx_bit(tx_bit), .line_in(line_in),
    .frame_evt(frame_evt), .coll_evt(coll_evt), .fault(fault)
  );

  dbg_break_gen #(.BREAK_CLKS(BREAK_CLKS)) u_break (
    .clk(clk), .rst_n(rst_n), .fault(fault), .line_in(line_in),
    .brk_active(brk_active), .ready(ready), .abort_p(abort_o), .brst_p(baud_rst_o)
  );

  assign pull_low_o = brk_active | (ready & tx_en & ~tx_bit);
  assign ready_o    = ready;

  // R4/R3: every fault source leads to an abort on the next cycle
  assert_fault_aborts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_evt || coll_evt || brk_evt) |=> abort_o);

endmodule

// File: tb/dbg_link_guard_test.sv
module dbg_link_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int BRK_BITS   = 9;
  localparam int BREAK_CLKS = 4096;
  localparam int BITP       = 8;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 0, samp_tick = 0, stop_vld = 0, stop_bit = 1;
  logic tx_en = 0, tx_bit = 1, host_low = 0;
  logic line_in;
  logic abort_o, baud_rst_o, pull_low_o, ready_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign line_in = !(pull_low_o || host_low);

  dbg_link_guard #(.BRK_BITS(BRK_BITS), .BREAK_CLKS(BREAK_CLKS)) uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .samp_tick(samp_tick),
    .stop_vld(stop_vld), .stop_bit(stop_bit), .tx_en(tx_en), .tx_bit(tx_bit),
    .line_in(line_in), .abort_o(abort_o), .baud_rst_o(baud_rst_o),
    .pull_low_o(pull_low_o), .ready_o(ready_o)
  );

  int errs = 0, checks = 0, cycles = 0;
  int ms = 0, mcnt = 0, mrun = 0;   // model: 0 ready, 1 break, 2 wait
  bit m_abort = 0;
  int n_abort = 0, n_pull = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_pull();
    return (ms == 1) || (ms == 0 && tx_en && !tx_bit);
  endfunction

  task automatic model_edge();
    bit line, err;
    line = !(exp_pull() || host_low);
    err = 0;
    m_abort = 0;
    if (ms == 0) begin
      if (!line) begin
        if (bit_tick && mrun + 1 == BRK_BITS) err = 1;
        if (bit_tick && mrun < BRK_BITS) mrun++;
      end else mrun = 0;
      if (stop_vld && !stop_bit) err = 1;
      if (samp_tick && tx_en && tx_bit && !line) err = 1;
      if (err) begin ms = 1; mcnt = 0; mrun = 0; m_abort = 1; end
    end else if (ms == 1) begin
      mcnt++;
      if (mcnt == BREAK_CLKS) ms = 2;
    end else begin
      if (line) ms = 0;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(abort_o == m_abort, "R5 abort_o", abort_o, m_abort);
    chk(baud_rst_o == m_abort, "R5 baud_rst_o", baud_rst_o, m_abort);
    chk(pull_low_o == exp_pull(), "R6/R9 pull_low_o", pull_low_o, exp_pull());
    chk(ready_o == (ms == 0), "R8 ready_o", ready_o, ms == 0);
    if (abort_o) n_abort++;
    if (pull_low_o) n_pull++;
    bit_tick = 0; samp_tick = 0; stop_vld = 0;
  endtask

  task automatic send_bits(int n, bit low);
    for (int i = 0; i < n; i++) begin
      host_low = low;
      repeat (BITP - 1) step();
      bit_tick = 1;
      step();
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errs++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(ready_o == 1, "R1 ready", ready_o, 1);
    chk(abort_o == 0 && baud_rst_o == 0, "R1 pulses", abort_o, 0);
    chk(pull_low_o == 0, "R1 pull", pull_low_o, 0);
    repeat (4) step();

    // R2: eight low bits tolerated
    n_abort = 0;
    send_bits(8, 1);
    host_low = 0; step();
    chk(n_abort == 0, "R2 eight low bits", n_abort, 0);
    // R2: nine low bits break
    n_abort = 0; n_pull = 0;
    send_bits(9, 1);
    chk(n_abort == 1 && abort_o == 1, "R2 ninth low bit", n_abort, 1);
    // R7: host keeps breaking with bit ticks through our break
    send_bits(520, 1);
    chk(n_abort == 1, "R7 no retrigger", n_abort, 1);
    chk(n_pull == BREAK_CLKS, "R6 break length", n_pull, BREAK_CLKS);
    chk(ready_o == 0, "R8 waits for high line", ready_o, 0);
    host_low = 0; step();
    chk(ready_o == 1, "R8 ready after high", ready_o, 1);

    // R3: framing
    n_abort = 0;
    stop_vld = 1; stop_bit = 1; step();
    chk(n_abort == 0, "R3 good stop", n_abort, 0);
    stop_vld = 1; stop_bit = 0; step();
    chk(n_abort == 1 && baud_rst_o == 1, "R3 bad stop", n_abort, 1);
    step();
    chk(abort_o == 0, "R5 single pulse", abort_o, 0);
    // R7: faults injected during break
    stop_vld = 1; stop_bit = 0; step();
    tx_en = 1; tx_bit = 1; samp_tick = 1; step();
    tx_en = 0; stop_bit = 1;
    repeat (4200) step();
    chk(n_abort == 1, "R7 ignored during break", n_abort, 1);
    chk(ready_o == 1, "R8 recovered", ready_o, 1);

    // R9: transmit drive
    n_abort = 0;
    tx_en = 1; tx_bit = 0; step();
    chk(pull_low_o == 1, "R9 drive zero", pull_low_o, 1);
    samp_tick = 1; step();
    chk(n_abort == 0, "R4 own zero no collision", n_abort, 0);
    tx_bit = 1; step();
    chk(pull_low_o == 0, "R9 release one", pull_low_o, 0);

    // R4: collision
    host_low = 1; step();
    chk(n_abort == 0, "R4 no strobe", n_abort, 0);
    samp_tick = 1; step();
    chk(n_abort == 1, "R4 collision", n_abort, 1);
    host_low = 0; tx_en = 0;
    repeat (4200) step();
    chk(ready_o == 1 && n_abort == 1, "R8 final ready", ready_o, 1);

    finish_run();
  end
endmodule